// File: doc/BRIEF.md
# Double-Buffered Synchronous Serial Master

This block is a master-only synchronous serial port. Its transmit side has two stages: a holding register and a shift register. A byte written while the shifter is busy waits in the holding register. That byte moves into the shifter on the same edge that ends the current byte, so a stream of bytes goes out on a serial clock with no gap between them. The serial clock rate comes from a divisor. Clock polarity, clock phase and bit order can all be selected. The block generates no chip-select, so external logic frames each transfer.

Software or a controller writes four addressed registers through one write port: data, configuration, divisor and flag-clear. It watches a buffer-empty flag to know when it can load the next byte. It watches a separate, sticky transmit-complete flag to know when the line has gone idle. When receive is enabled, the block captures one byte per transmitted byte into a two-entry FIFO. Nothing empties that FIFO except pops, and it reports overrun.

Top module: `sync_ser_master`

## Requirements
- R1: Configuration register (address 1) bit 0 selects the idle level of `sck_o` and bit 1 selects the phase. With phase 0 the peripheral samples on the first clock edge of each bit. With phase 1 it samples on the second edge. The block samples `miso_i` on that same edge.
- R2: Configuration bit 2 set sends and receives least significant bit first. Clear, it sends and receives most significant bit first.
- R3: A byte written to the data register (address 0) while a byte is shifting moves into the shifter at the end of that byte. Two such bytes produce 16 serial clock periods of equal length, with no gap.
- R4: `dre_o` is high exactly when the holding register is empty. A data write while it is full is ignored.
- R5: `txc_o` is set when a byte ends with no byte waiting. It stays set until a write to address 3 with bit 0 set, or until a pulse on `irq_ack_i`. A write to address 3 with bit 0 clear leaves it unchanged.
- R6: Each half period of `sck_o` lasts divisor+1 clock cycles, where the divisor is written at address 2. A divisor of 0 gives half the system clock.
- R7: A divisor written during a byte takes effect only from the next byte.
- R8: With configuration bit 3 set at the start of a byte, the received byte is pushed to the FIFO at the end of that byte. With bit 3 clear, nothing is pushed.
- R9: The receive FIFO holds two bytes, and contents persist until popped with `rx_pop_i`. A byte that arrives while the FIFO is full is dropped and sets `rx_ovr_o`. A write to address 3 with bit 1 set clears `rx_ovr_o`.
- R10: `irq_o` is (`txc_o` AND configuration bit 4) OR (`dre_o` AND configuration bit 5).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address: 0 data, 1 config, 2 divisor, 3 flag clear |
| wr_data_i | input | 8 | Write data |
| rx_pop_i | input | 1 | Remove the head byte of the receive FIFO |
| irq_ack_i | input | 1 | Interrupt acknowledge; clears transmit-complete |
| miso_i | input | 1 | Serial data in |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| dre_o | output | 1 | Holding register empty |
| txc_o | output | 1 | Transmit complete, sticky |
| rx_data_o | output | 8 | Head byte of the receive FIFO |
| rx_valid_o | output | 1 | Receive FIFO not empty |
| rx_ovr_o | output | 1 | Receive overrun, sticky |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check the cycle-level rules on every cycle:
- the half-period state holds between divider ticks;
- a waiting byte reloads the shifter on the final edge with no idle cycle;
- an ignored write leaves the holding register intact;
- the transmit-complete flag stays set until it is cleared and rises only when the shifter goes idle;
- an overflowing push raises the overrun flag;
- the FIFO head stays put when nothing is popped.

Only the bench scenarios can show the serial waveform itself: the bit order seen on the sampling edges of each clock mode, the measured clock periods per divisor, the exact 16-period gapless burst, and the byte on which a new divisor takes effect.

// File: rtl/ssm_pkg.sv
package ssm_pkg;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_DATA = 2'd0;
  localparam logic [ADDR_W-1:0] A_CFG  = 2'd1;
  localparam logic [ADDR_W-1:0] A_DIV  = 2'd2;
  localparam logic [ADDR_W-1:0] A_CLR  = 2'd3;

  localparam int C_CPOL  = 0;
  localparam int C_CPHA  = 1;
  localparam int C_LSB   = 2;
  localparam int C_RXEN  = 3;
  localparam int C_TXCIE = 4;
  localparam int C_DREIE = 5;

  localparam int S_TXC = 0;
  localparam int S_OVR = 1;
endpackage

// File: rtl/ssm_clkgen.sv
module ssm_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (!run_i || tick_o)    cnt_q <= '0;
    else                          cnt_q <= cnt_q + 1'b1;
  end

  // R6
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !tick_o) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/ssm_shifter.sv
module ssm_shifter #(
  parameter int W     = 8,
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hold_full_i,
  input  logic [W-1:0]     hold_data_i,
  input  logic             cpol_i,
  input  logic             cpha_i,
  input  logic             lsb_i,
  input  logic             rx_en_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             miso_i,
  output logic             take_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             sck_o,
  output logic             mosi_o,
  output logic             rx_push_o,
  output logic [W-1:0]     rx_byte_o
);
  localparam int BIT_W = $clog2(W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(W-1);

  logic             busy_q, half_q;
  logic [BIT_W-1:0] bit_q;
  logic [W-1:0]     tx_sr_q, rx_sr_q;
  logic             cpol_l, cpha_l, lsb_l, rxen_l;
  logic [DIV_W-1:0] div_l;
  logic             tick, last_edge, sck_act;

  ssm_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy_q),
    .div_i  (div_l),
    .tick_o (tick)
  );

  assign last_edge = busy_q && tick && half_q && (bit_q == LAST_BIT);
  assign take_o    = hold_full_i && (!busy_q || last_edge);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      half_q  <= 1'b0;
      bit_q   <= '0;
      tx_sr_q <= '0;
      rx_sr_q <= '0;
      cpol_l  <= 1'b0;
      cpha_l  <= 1'b0;
      lsb_l   <= 1'b0;
      rxen_l  <= 1'b0;
      div_l   <= '0;
    end else if (take_o) begin
      busy_q  <= 1'b1;
      half_q  <= 1'b0;
      bit_q   <= '0;
      tx_sr_q <= hold_data_i;
      cpol_l  <= cpol_i;
      cpha_l  <= cpha_i;
      lsb_l   <= lsb_i;
      rxen_l  <= rx_en_i;
      div_l   <= div_i;
    end else if (last_edge) begin
      busy_q <= 1'b0;
      half_q <= 1'b0;
    end else if (busy_q && tick) begin
      if (!half_q) begin
        half_q  <= 1'b1;
        rx_sr_q <= lsb_l ? {miso_i, rx_sr_q[W-1:1]} : {rx_sr_q[W-2:0], miso_i};
      end else begin
        half_q  <= 1'b0;
        bit_q   <= bit_q + 1'b1;
        tx_sr_q <= lsb_l ? {1'b0, tx_sr_q[W-1:1]} : {tx_sr_q[W-2:0], 1'b0};
      end
    end
  end

  // phase 0: clock active in second half; phase 1: in first half
  assign sck_act   = cpha_l ? !half_q : half_q;
  assign sck_o     = busy_q ? (cpol_l ^ sck_act) : cpol_i;
  assign mosi_o    = lsb_l ? tx_sr_q[0] : tx_sr_q[W-1];
  assign busy_o    = busy_q;
  assign done_o    = last_edge;
  assign rx_push_o = last_edge && rxen_l;
  assign rx_byte_o = rx_sr_q;

  // R6
  half_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !tick) |=> (busy_q && $stable(half_q) && $stable(bit_q)));

  // R3
  gapless_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_edge && hold_full_i) |=> (busy_q && bit_q == '0 && !half_q));
endmodule

// File: rtl/ssm_rx_fifo.sv
module ssm_rx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  input  logic         clr_ovr_i,
  output logic [W-1:0] head_o,
  output logic         valid_o,
  output logic         ovr_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_MAX = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             full, do_pop, do_push, ovr_q;

  assign full    = (cnt_q == CNT_FULL);
  assign do_pop  = pop_i && (cnt_q != '0);
  assign do_push = push_i && (!full || do_pop);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      if (do_push) begin
        mem_q[wr_q] <= data_i;
        wr_q <= (wr_q == PTR_MAX) ? '0 : wr_q + 1'b1;
      end
      if (do_pop) rd_q <= (rd_q == PTR_MAX) ? '0 : rd_q + 1'b1;
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
      if (push_i && !do_push) ovr_q <= 1'b1;
      else if (clr_ovr_i)     ovr_q <= 1'b0;
    end
  end

  assign head_o  = mem_q[rd_q];
  assign valid_o = (cnt_q != '0);
  assign ovr_o   = ovr_q;

  // R9
  overflow_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full && !pop_i) |=> ovr_q);

  // R9
  not_flushed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0 && !pop_i) |=> (valid_o && $stable(head_o)));
endmodule

// File: rtl/sync_ser_master.sv
module sync_ser_master
  import ssm_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int DIV_W      = 8,
  parameter int FIFO_DEPTH = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rx_pop_i,
  input  logic              irq_ack_i,
  input  logic              miso_i,
  output logic              sck_o,
  output logic              mosi_o,
  output logic              dre_o,
  output logic              txc_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              rx_ovr_o,
  output logic              irq_o
);
  logic              wr_dat, wr_cfg, wr_div, clr_txc, clr_ovr;
  logic [DATA_W-1:0] hold_q;
  logic              hold_full_q, txc_q;
  logic              cpol_q, cpha_q, lsb_q, rxen_q, txcie_q, dreie_q;
  logic [DIV_W-1:0]  div_q;
  logic              take, busy, done, rx_push;
  logic [DATA_W-1:0] rx_byte;

  assign wr_dat  = wr_en_i && (wr_addr_i == A_DATA);
  assign wr_cfg  = wr_en_i && (wr_addr_i == A_CFG);
  assign wr_div  = wr_en_i && (wr_addr_i == A_DIV);
  assign clr_txc = (wr_en_i && (wr_addr_i == A_CLR) && wr_data_i[S_TXC]) || irq_ack_i;
  assign clr_ovr = wr_en_i && (wr_addr_i == A_CLR) && wr_data_i[S_OVR];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q      <= '0;
      hold_full_q <= 1'b0;
      txc_q       <= 1'b0;
      cpol_q      <= 1'b0;
      cpha_q      <= 1'b0;
      lsb_q       <= 1'b0;
      rxen_q      <= 1'b0;
      txcie_q     <= 1'b0;
      dreie_q     <= 1'b0;
      div_q       <= '0;
    end else begin
      if (wr_dat && !hold_full_q) begin
        hold_q      <= wr_data_i;
        hold_full_q <= 1'b1;
      end else if (take) begin
        hold_full_q <= 1'b0;
      end
      if (done && !take) txc_q <= 1'b1;
      else if (clr_txc)  txc_q <= 1'b0;
      if (wr_cfg) begin
        cpol_q  <= wr_data_i[C_CPOL];
        cpha_q  <= wr_data_i[C_CPHA];
        lsb_q   <= wr_data_i[C_LSB];
        rxen_q  <= wr_data_i[C_RXEN];
        txcie_q <= wr_data_i[C_TXCIE];
        dreie_q <= wr_data_i[C_DREIE];
      end
      if (wr_div) div_q <= wr_data_i[DIV_W-1:0];
    end
  end

  ssm_shifter #(.W(DATA_W), .DIV_W(DIV_W)) u_shifter (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hold_full_i (hold_full_q),
    .hold_data_i (hold_q),
    .cpol_i      (cpol_q),
    .cpha_i      (cpha_q),
    .lsb_i       (lsb_q),
    .rx_en_i     (rxen_q),
    .div_i       (div_q),
    .miso_i      (miso_i),
    .take_o      (take),
    .busy_o      (busy),
    .done_o      (done),
    .sck_o       (sck_o),
    .mosi_o      (mosi_o),
    .rx_push_o   (rx_push),
    .rx_byte_o   (rx_byte)
  );

  ssm_rx_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .push_i    (rx_push),
    .data_i    (rx_byte),
    .pop_i     (rx_pop_i),
    .clr_ovr_i (clr_ovr),
    .head_o    (rx_data_o),
    .valid_o   (rx_valid_o),
    .ovr_o     (rx_ovr_o)
  );

  assign dre_o = !hold_full_q;
  assign txc_o = txc_q;
  assign irq_o = (txc_q && txcie_q) || (!hold_full_q && dreie_q);

  // R4
  ignored_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_full_q && wr_dat) |=> $stable(hold_q));

  // R5
  txc_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(txc_q) |-> !busy);

  // R5
  txc_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txc_q && !clr_txc) |=> txc_q);
endmodule

// File: tb/sync_ser_master_tb_top.sv
module sync_ser_master_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       rx_pop = 1'b0;
  logic       irq_ack = 1'b0;
  logic       sck, mosi, dre, txc, rx_valid, rx_ovr, irq;
  logic [7:0] rx_data;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  sync_ser_master dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rx_pop_i(rx_pop), .irq_ack_i(irq_ack), .miso_i(mosi),
    .sck_o(sck), .mosi_o(mosi), .dre_o(dre), .txc_o(txc), .rx_data_o(rx_data),
    .rx_valid_o(rx_valid), .rx_ovr_o(rx_ovr), .irq_o(irq)
  );

  // serial monitor
  logic        tb_cpol = 1'b0, tb_cpha = 1'b0, mon_en = 1'b0, prev_sck = 1'b0;
  logic [15:0] cap = '0;
  int cyc = 0, n_smp = 0, n_lead = 0, last_lead = 0, gmin = 0, gmax = 0;

  always @(negedge clk) begin
    cyc++;
    if (mon_en && sck !== prev_sck) begin
      if ((sck != tb_cpol) == !tb_cpha) begin
        cap = {cap[14:0], mosi};
        n_smp++;
      end
      if (sck != tb_cpol) begin
        if (n_lead > 0) begin
          if (cyc - last_lead < gmin) gmin = cyc - last_lead;
          if (cyc - last_lead > gmax) gmax = cyc - last_lead;
        end
        n_lead++;
        last_lead = cyc;
      end
    end
    prev_sck = sck;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pop();
    @(negedge clk); rx_pop = 1'b1;
    @(negedge clk); rx_pop = 1'b0;
  endtask

  task automatic mon_start(input logic pol, input logic pha);
    tb_cpol = pol; tb_cpha = pha;
    repeat (2) @(negedge clk);
    cap = '0; n_smp = 0; n_lead = 0; gmin = 1000; gmax = 0;
    mon_en = 1'b1;
  endtask

  task automatic wait_txc();
    while (txc !== 1'b1) @(negedge clk);
    @(negedge clk);
    mon_en = 1'b0;
  endtask

  function automatic logic [7:0] rev8(input logic [7:0] v);
    for (int i = 0; i < 8; i++) rev8[i] = v[7-i];
  endfunction

  // {cpol, cpha, lsb_first, divisor, data}
  localparam logic [18:0] VEC [0:7] = '{
    {1'b0, 1'b0, 1'b0, 8'd0, 8'hA5},
    {1'b0, 1'b1, 1'b0, 8'd1, 8'h3C},
    {1'b1, 1'b0, 1'b0, 8'd2, 8'h96},
    {1'b1, 1'b1, 1'b0, 8'd0, 8'h5A},
    {1'b0, 1'b0, 1'b1, 8'd1, 8'hC1},
    {1'b0, 1'b1, 1'b1, 8'd3, 8'h0F},
    {1'b1, 1'b0, 1'b1, 8'd0, 8'h81},
    {1'b1, 1'b1, 1'b1, 8'd2, 8'h7E}
  };

  initial begin
    repeat (1500000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R4 reset dre", 32'(dre), 1);
    chk("R5 reset txc", 32'(txc), 0);
    chk("R10 reset irq", 32'(irq), 0);
    chk("R9 reset rx_valid", 32'(rx_valid), 0);
    chk("R1 reset sck", 32'(sck), 0);

    // table walk: modes, orders, divisors
    for (int v = 0; v < 8; v++) begin
      logic pol, pha, lsb;
      logic [7:0] dv, dt;
      {pol, pha, lsb, dv, dt} = VEC[v];
      wr(2'd1, {4'b0001, lsb, pha, pol});
      wr(2'd2, dv);
      wr(2'd3, 8'h03);
      mon_start(pol, pha);
      chk("R1 idle level", 32'(sck), 32'(pol));
      wr(2'd0, dt);
      wait_txc();
      chk("R1 sample count", n_smp, 8);
      if (lsb) chk("R2 lsb first", 32'(rev8(cap[7:0])), 32'(dt));
      else     chk("R1 msb first", 32'(cap[7:0]), 32'(dt));
      chk("R6 min period", gmin, 2 * (dv + 1));
      chk("R6 max period", gmax, 2 * (dv + 1));
      chk("R8 rx valid", 32'(rx_valid), 1);
      chk("R8 rx byte", 32'(rx_data), 32'(dt));
      pop();
    end

    // R3 gapless pair
    wr(2'd1, 8'h08); wr(2'd2, 8'd1); wr(2'd3, 8'h03);
    mon_start(1'b0, 1'b0);
    wr(2'd0, 8'h3C);
    wr(2'd0, 8'hC3);
    chk("R4 dre low when held", 32'(dre), 0);
    wait_txc();
    chk("R3 clock count", n_lead, 16);
    chk("R3 min period", gmin, 4);
    chk("R3 max period", gmax, 4);
    chk("R3 stream", 32'(cap), 32'h3CC3);
    chk("R4 dre after drain", 32'(dre), 1);
    chk("R8 first rx", 32'(rx_data), 32'h3C);
    pop();
    chk("R8 second rx", 32'(rx_data), 32'hC3);
    pop();

    // R4 third write while held is ignored
    wr(2'd3, 8'h01);
    mon_start(1'b0, 1'b0);
    wr(2'd0, 8'hA1); wr(2'd0, 8'hB2); wr(2'd0, 8'hC4);
    wait_txc();
    chk("R4 ignored write clocks", n_lead, 16);
    chk("R4 ignored write stream", 32'(cap), 32'hA1B2);
    pop(); pop();
    chk("R4 no third rx", 32'(rx_valid), 0);

    // R5 sticky flag and clears; R10 interrupt
    repeat (50) @(negedge clk);
    chk("R5 txc sticky", 32'(txc), 1);
    wr(2'd3, 8'h00);
    chk("R5 zero write keeps txc", 32'(txc), 1);
    wr(2'd1, 8'h18);
    chk("R10 txc irq", 32'(irq), 1);
    @(negedge clk); irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    chk("R5 ack clears txc", 32'(txc), 0);
    chk("R10 irq drops", 32'(irq), 0);
    wr(2'd1, 8'h28);
    chk("R10 dre irq", 32'(irq), 1);
    wr(2'd1, 8'h08);
    wr(2'd0, 8'h11);
    wait_txc();
    wr(2'd3, 8'h01);
    chk("R5 write clears txc", 32'(txc), 0);
    pop();

    // R7 divisor change mid-byte
    wr(2'd2, 8'd1);
    mon_start(1'b0, 1'b0);
    wr(2'd0, 8'h55);
    repeat (6) @(negedge clk);
    wr(2'd2, 8'd3);
    wait_txc();
    chk("R7 old divisor min", gmin, 4);
    chk("R7 old divisor max", gmax, 4);
    wr(2'd3, 8'h01);
    mon_start(1'b0, 1'b0);
    wr(2'd0, 8'hAA);
    wait_txc();
    chk("R7 new divisor", gmax, 8);
    pop(); pop();

    // R8 receive disabled
    wr(2'd1, 8'h00); wr(2'd3, 8'h01);
    wr(2'd0, 8'h77);
    wait_txc();
    chk("R8 rx disabled", 32'(rx_valid), 0);

    // R9 overrun, no flush
    wr(2'd1, 8'h08); wr(2'd2, 8'd0);
    wr(2'd3, 8'h01); wr(2'd0, 8'h11); wait_txc();
    wr(2'd3, 8'h01); wr(2'd0, 8'h22); wait_txc();
    chk("R9 no early overrun", 32'(rx_ovr), 0);
    wr(2'd3, 8'h01); wr(2'd0, 8'h33); wait_txc();
    chk("R9 overrun set", 32'(rx_ovr), 1);
    chk("R9 head kept", 32'(rx_data), 32'h11);
    pop();
    chk("R9 second entry", 32'(rx_data), 32'h22);
    pop();
    chk("R9 dropped byte", 32'(rx_valid), 0);
    wr(2'd3, 8'h02);
    chk("R9 overrun cleared", 32'(rx_ovr), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule